// File: doc/BRIEF.md
# Pseudo Fault Injection Countdown Timer

This block is a small timer that produces artificial error events so that downstream error-handling logic can be exercised on purpose. Software programs a countdown value and a control word over a simple register bus. Setting the arm bit copies the countdown value into an internal counter, which then steps down by one every clock cycle.

When the count expires, the block fires a trigger. For each of three severity classes (corrected, deferred and uncontainable) it emits a one-cycle injection pulse, provided the enable bit for that class is set. After a trigger the timer either halts or reloads itself and runs again, depending on the repeat bit. Clearing the arm bit stops the timer at once.

Top module: `fault_inject_timer`

## Requirements
- R1: After reset both registers read 0 and all three injection outputs are low.
- R2: The control register sits at word address 0. Only bits 31 (arm), 30 (repeat), 6 (corrected), 5 (deferred) and 1 (uncontainable) hold data, so the writable mask is 0xC0000062. Every other bit reads 0, whatever was written to it.
- R3: The countdown register sits at word address 1. It holds all 32 bits written to it and reads them back unchanged.
- R4: A control write with bit 31 set loads the countdown value N into the counter. The first trigger pulse appears N rising edges after the write edge when N ≥ 1, and 1 edge after it when N = 0. Once armed, the counter falls by one on each cycle.
- R5: Each trigger drives every enabled output high for exactly one clock cycle.
- R6: With bit 30 clear, the timer stops after its first trigger and produces no further pulse.
- R7: With bit 30 set, the timer reloads the current countdown value at each trigger. Pulses then repeat every N cycles, or every cycle when N = 0.
- R8: At a trigger, `inj_corrected` pulses only if bit 6 is set, `inj_deferred` only if bit 5 is set, and `inj_uncontainable` only if bit 1 is set. A class whose bit is clear stays low.
- R9: A control write with bit 31 clear halts the counter. This includes a write on the very edge at which a pulse would otherwise have appeared. No pulse occurs until the timer is armed again.
- R10: Addresses other than 0 and 1 read 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Word address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| inj_corrected | output | 1 | Corrected-class injection pulse |
| inj_deferred | output | 1 | Deferred-class injection pulse |
| inj_uncontainable | output | 1 | Uncontainable-class injection pulse |

## Verification
The assertions assume that a write strobe lasts one cycle per access and that the address is stable while the strobe is high. They also assume the class enables may change between triggers, because each pulse is checked against the enable value held in the cycle before it. The bench drives every access for exactly one cycle from the falling edge. It times its disabling writes so that they land on chosen edges, including the edge of a due pulse. It leaves the control word alone while a programmed countdown is running, except for those deliberate stop writes.

// File: rtl/fit_pkg.sv
package fit_pkg;
    parameter int DATA_W = 32;
    parameter int CNT_W  = 32;
    parameter int NCLS   = 3;

    localparam int BIT_ARM    = 31;
    localparam int BIT_REPEAT = 30;
    localparam int BIT_CORR   = 6;
    localparam int BIT_DEFER  = 5;
    localparam int BIT_UNCON  = 1;

    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << BIT_ARM) | (DATA_W'(1) << BIT_REPEAT) |
        (DATA_W'(1) << BIT_CORR) | (DATA_W'(1) << BIT_DEFER) |
        (DATA_W'(1) << BIT_UNCON);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] reload;
    } regs_t;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } cnt_t;
endpackage

// File: rtl/fit_regs.sv
module fit_regs
    import fit_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int CTRL_ADDR   = 0,
    parameter int RELOAD_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] reload,
    output logic              ctrl_wr
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(RELOAD_ADDR);

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        ctrl_wr = wr && (addr == A_CTRL);
        if (ctrl_wr)
            r_d.ctrl = wdata & CTRL_MASK;
        if (wr && (addr == A_RELOAD))
            r_d.reload = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = r_q.ctrl;
            A_RELOAD: rdata = r_q.reload;
            default:  rdata = '0;
        endcase
    end

    assign ctrl   = r_q.ctrl;
    assign reload = r_q.reload;
endmodule

// File: rtl/fit_count.sv
module fit_count
    import fit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             arm_wr,
    input  logic             en,
    input  logic             repeat_en,
    input  logic [CNT_W-1:0] reload,
    output logic             fire,
    output logic             running,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_t c_d, c_q;

    always_comb begin
        c_d  = c_q;
        fire = 1'b0;
        if (ctrl_wr) begin
            // any control write restarts or halts; a due trigger is dropped
            c_d.run = arm_wr;
            c_d.cnt = arm_wr ? reload : c_q.cnt;
        end else if (c_q.run && en) begin
            if (c_q.cnt <= ONE) begin
                fire = 1'b1;
                if (repeat_en) begin
                    c_d.cnt = reload;
                end else begin
                    c_d.cnt = '0;
                    c_d.run = 1'b0;
                end
            end else begin
                c_d.cnt = c_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign running = c_q.run;
    assign count   = c_q.cnt;
endmodule

// File: rtl/fit_pulse.sv
module fit_pulse
    import fit_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [NCLS-1:0] cls_en,
    output logic [NCLS-1:0] pulse
);
    logic [NCLS-1:0] p_d, p_q;

    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        always_comb p_d[g] = fire & cls_en[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pulse = p_q;
endmodule

// File: rtl/fault_inject_timer.sv
module fault_inject_timer
    import fit_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              inj_corrected,
    output logic              inj_deferred,
    output logic              inj_uncontainable
);
    logic [DATA_W-1:0] ctrl_w, reload_w;
    logic              ctrl_wr_w, fire_w, run_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [NCLS-1:0]   pulse_w;

    fit_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(0), .RELOAD_ADDR(1)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .ctrl    (ctrl_w),
        .reload  (reload_w),
        .ctrl_wr (ctrl_wr_w)
    );

    fit_count u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr_w),
        .arm_wr    (bus_wdata[BIT_ARM]),
        .en        (ctrl_w[BIT_ARM]),
        .repeat_en (ctrl_w[BIT_REPEAT]),
        .reload    (reload_w),
        .fire      (fire_w),
        .running   (run_w),
        .count     (cnt_w)
    );

    fit_pulse u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire_w),
        .cls_en ({ctrl_w[BIT_CORR], ctrl_w[BIT_DEFER], ctrl_w[BIT_UNCON]}),
        .pulse  (pulse_w)
    );

    assign inj_corrected     = pulse_w[2];
    assign inj_deferred      = pulse_w[1];
    assign inj_uncontainable = pulse_w[0];
endmodule

// File: rtl/fit_checker.sv
module fit_checker
    import fit_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] ctrl_w,
    input logic              run_w,
    input logic [CNT_W-1:0]  cnt_w,
    input logic              inj_corrected,
    input logic              inj_deferred,
    input logic              inj_uncontainable
);
    logic any_inj, ctrl_access;
    assign any_inj     = inj_corrected | inj_deferred | inj_uncontainable;
    assign ctrl_access = bus_wr && (bus_addr == '0);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w & ~CTRL_MASK) == '0); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && $past(run_w) && !$past(ctrl_access) && $past(cnt_w) > 1)
        |-> cnt_w == $past(cnt_w) - 1); // R4

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (any_inj && !$past(ctrl_w[BIT_REPEAT]) && !$past(ctrl_access))
        |-> !run_w); // R6

    AST_GATE_CORR: assert property (@(posedge clk) disable iff (!rst_n)
        inj_corrected |-> $past(ctrl_w[BIT_CORR])); // R8

    AST_GATE_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        inj_deferred |-> $past(ctrl_w[BIT_DEFER])); // R8

    AST_GATE_UNCON: assert property (@(posedge clk) disable iff (!rst_n)
        inj_uncontainable |-> $past(ctrl_w[BIT_UNCON])); // R8

    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_w[BIT_ARM] |-> !any_inj); // R9
endmodule

bind fault_inject_timer fit_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_wr            (bus_wr),
    .bus_addr          (bus_addr),
    .ctrl_w            (ctrl_w),
    .run_w             (run_w),
    .cnt_w             (cnt_w),
    .inj_corrected     (inj_corrected),
    .inj_deferred      (inj_deferred),
    .inj_uncontainable (inj_uncontainable)
);

// File: tb/sim_fault_inject_timer.sv
`timescale 1ns/1ps
module sim_fault_inject_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        inj_corrected, inj_deferred, inj_uncontainable;

    fault_inject_timer u0 (.*);

    always #4 clk = ~clk;  // 125 MHz

    typedef struct { int cyc; logic [2:0] m; } exp_t;
    exp_t sb[$];
    int cyc = 0;
    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: mask order {corrected, deferred, uncontainable}
    always @(negedge clk) begin
        logic [2:0] seen;
        seen = {inj_corrected, inj_deferred, inj_uncontainable};
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].cyc < cyc) begin
                compared++; mismatched++;
                $display("FAIL R4/R7 pulse missing at cycle %0d (actual none, expected mask %b)",
                         sb[0].cyc, sb[0].m);
                void'(sb.pop_front());
            end
            if (seen != 3'b000) begin
                compared++;
                if (sb.size() == 0) begin
                    mismatched++;
                    $display("FAIL R5/R6/R9 unexpected pulse cycle %0d mask %b (expected none)", cyc, seen);
                end else if (sb[0].cyc != cyc || sb[0].m != seen) begin
                    mismatched++;
                    $display("FAIL R4/R8 pulse cycle %0d mask %b (expected cycle %0d mask %b)",
                             cyc, seen, sb[0].cyc, sb[0].m);
                    void'(sb.pop_front());
                end else begin
                    void'(sb.pop_front());
                end
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int edge_no);
        @(negedge clk);
        edge_no = cyc + 1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // driver: programs and arms, pushes expected pulses into the scoreboard
    task automatic arm(input logic [31:0] n, input logic [31:0] c, input int npulse, output int w);
        int e;
        int p;
        logic [2:0] m;
        wr(4'd1, n, e);
        m = {c[6], c[5], c[1]};
        p = (n == 0) ? 1 : int'(n);
        wr(4'd0, c, w);
        for (int k = 1; k <= npulse; k++) sb.push_back('{w + p * k, m});
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic drained(string req);
        compared++;
        if (sb.size() != 0) begin
            mismatched++;
            $display("FAIL %s pending pulses actual %0d expected 0", req, sb.size());
            sb.delete();
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog expired (actual running, expected finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int w, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'd0, d); check("R1 ctrl", d, 32'h0);
        rd(4'd1, d); check("R1 reload", d, 32'h0);
        check("R1 outputs", {29'd0, inj_corrected, inj_deferred, inj_uncontainable}, 32'h0);

        // R3: reload readback
        wr(4'd1, 32'hA5A5_1234, e);
        rd(4'd1, d); check("R3 reload", d, 32'hA5A5_1234);

        // R2: reserved bits read zero (arm left clear)
        wr(4'd0, 32'h7FFF_FFFF, e);
        rd(4'd0, d); check("R2 ctrl mask", d, 32'h4000_0062);
        wr(4'd0, 32'h0, e);
        rd(4'd0, d); check("R2 ctrl clear", d, 32'h0);

        // R10: unmapped address
        wr(4'd2, 32'hFFFF_FFFF, e);
        rd(4'd2, d); check("R10 unmapped read", d, 32'h0);
        rd(4'd0, d); check("R10 ctrl untouched", d, 32'h0);
        rd(4'd1, d); check("R10 reload untouched", d, 32'hA5A5_1234);

        // R4 R5 R6 R8: one-shot N=5, corrected only
        arm(32'd5, 32'h8000_0040, 1, w);
        wait_until(w + 25);
        drained("R6 one-shot");

        // R4: N=0 immediate trigger, all classes
        arm(32'd0, 32'h8000_0062, 1, w);
        wait_until(w + 10);
        drained("R4 zero reload");

        // R7 R9: repeat N=4, deferred+uncontainable, stop on the due edge w+20
        arm(32'd4, 32'hC000_0022, 4, w);
        wait_until(w + 18);
        wr(4'd0, 32'h4000_0022, e);
        check("R9 stop edge", e, w + 20);
        wait_until(w + 35);
        drained("R7 repeat");

        // R9: halt mid-count
        arm(32'd10, 32'h8000_0062, 0, w);
        wait_until(w + 3);
        wr(4'd0, 32'h0000_0062, e);
        wait_until(w + 30);
        drained("R9 halt");
        rd(4'd0, d); check("R9 ctrl after halt", d, 32'h0000_0062);

        // R7 R8: repeat N=1, uncontainable only, pulses every cycle
        arm(32'd1, 32'hC000_0002, 3, w);
        wait_until(w + 2);
        wr(4'd0, 32'h0, e);
        wait_until(w + 12);
        drained("R7 period one");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule